// File: doc/BRIEF.md
# Triggered Waveform Capture Engine

This block watches a bus of debug probe bits and, once a host-programmed start condition is seen, writes one probe snapshot per clock into an on-chip sample memory until that memory is full. A host controls it through a simple read/write register bus. Before setting up a capture, the host can read the probe width, the sample depth and a version word. It then programs four per-bit condition masks and arms the engine. It polls for completion, or cancels a capture that never starts, and reads the samples back one at a time through an index register and a data register.

There are four start conditions per probe bit: rising edge, falling edge, high level and low level. An edge is judged against the bit's value in the previous clock cycle. A bit is satisfied when any of its enabled conditions holds. Capture starts in the first cycle in which every bit that has at least one condition enabled is satisfied. When no condition is enabled anywhere, capture starts in the first cycle after arming.

The engine owns the top sixteen words of the 32-bit register address space. Any bus access outside that window is flagged on `user_sel` so that neighbouring user registers decode only there.

Top module: `trig_capture`

## Requirements
- R1: After reset the status word, every condition mask, the sample index and `bus_rdata` read as zero.
- R2: Offset 2 reads the probe width NBITS, offset 3 reads the sample depth DEPTH and offset 4 reads the VERSION parameter. All are zero-extended to 32 bits.
- R3: Writing offset 0 with bit 0 set arms the engine. From the next cycle, status (offset 1) bit 0 (waiting) is set or capture has begun, and bit 2 (done) is clear.
- R4: With all masks zero, the probe value of the first cycle after the arm write is stored at sample index 0, and status bit 1 (capturing) is set from then on.
- R5: Rising and falling edge conditions (masks at offsets 5 and 6, bit i for probe bit i) compare each bit with its value in the previous cycle. A bit that is already high when the engine is armed does not count as a rising edge.
- R6: High and low level conditions (masks at offsets 7 and 8) are met while the probe bit is 1, respectively 0.
- R7: Within one probe bit, any one of its enabled conditions is enough.
- R8: Across probe bits, capture starts only in a cycle in which every bit with a non-empty condition set is satisfied. Until then the engine stays waiting.
- R9: The trigger-cycle sample goes to index 0 and the following cycles go to consecutive indices. After index DEPTH-1 is written, capturing and waiting clear and done sets. Done stays set until the next arm.
- R10: Writing offset 0 with bit 1 set clears waiting and capturing and leaves done unchanged. Cancel takes priority over a simultaneous arm.
- R11: Offset 9 holds the sample index (read/write). Reading offset 10 returns the stored sample at that index, zero-extended.
- R12: Only addresses 0xFFFFFFF0 to 0xFFFFFFFF reach the engine, using the low four bits as the offset. Any other read or write raises `user_sel` in the same cycle and changes no engine state.
- R13: `bus_rdata` takes its new value at the clock edge that samples `bus_rd` and holds it in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_in | input | NBITS | Debug bits to watch and record |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 32 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| user_sel | output | 1 | Access falls outside the engine's window |

## Verification
On every cycle, the assertions check the following: the waiting, capturing and done flags are mutually exclusive; done persists until an arm; cancel forces the engine idle; waiting persists while the condition is unmet; the trigger writes index 0; reserved-window accesses never raise `user_sel`; and read data holds between reads. Only the bench scenarios can show the trigger semantics. That covers edge against previous value, no false edge at arm, OR within a bit, AND across bits, the exact samples that land in memory, and the configuration words, all compared cycle by cycle with a behavioural model.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FILL = 2'd2
  } cap_state_e;

  // address window tag for addr[31:4]
  localparam logic [27:0] RSV_TAG = 28'hFFF_FFFF;

  localparam logic [3:0] OFF_CTRL  = 4'd0;
  localparam logic [3:0] OFF_STAT  = 4'd1;
  localparam logic [3:0] OFF_WIDTH = 4'd2;
  localparam logic [3:0] OFF_DEPTH = 4'd3;
  localparam logic [3:0] OFF_VER   = 4'd4;
  localparam logic [3:0] OFF_RISE  = 4'd5;
  localparam logic [3:0] OFF_FALL  = 4'd6;
  localparam logic [3:0] OFF_HIGH  = 4'd7;
  localparam logic [3:0] OFF_LOW   = 4'd8;
  localparam logic [3:0] OFF_INDEX = 4'd9;
  localparam logic [3:0] OFF_DATA  = 4'd10;

  // one probe bit meets one of its enabled conditions
  function automatic logic bit_met(input logic cur, input logic prv,
                                   input logic er, input logic ef,
                                   input logic eh, input logic el);
    return (er & cur & ~prv) | (ef & ~cur & prv) | (eh & cur) | (el & ~cur);
  endfunction

  // probe bit takes part in the trigger at all
  function automatic logic bit_used(input logic er, input logic ef,
                                    input logic eh, input logic el);
    return er | ef | eh | el;
  endfunction

endpackage

// File: rtl/wcap_trig.sv
module wcap_trig
  import wcap_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] probe,
  input  logic [W-1:0] en_rise,
  input  logic [W-1:0] en_fall,
  input  logic [W-1:0] en_high,
  input  logic [W-1:0] en_low,
  output logic         hit
);

  logic [W-1:0] prev_q;
  logic [W-1:0] bit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= probe;
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign bit_ok[gi] = !bit_used(en_rise[gi], en_fall[gi], en_high[gi], en_low[gi])
                     || bit_met(probe[gi], prev_q[gi],
                                en_rise[gi], en_fall[gi], en_high[gi], en_low[gi]);
  end

  assign hit = &bit_ok;

endmodule

// File: rtl/wcap_ctrl.sv
module wcap_ctrl
  import wcap_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          cancel,
  input  logic          hit,
  output logic          armed,
  output logic          filling,
  output logic          done,
  output logic          fire,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  cap_state_e    st_q;
  logic [AW-1:0] cnt_q;
  logic          last;

  assign armed   = (st_q == ST_WAIT);
  assign filling = (st_q == ST_FILL);
  assign fire    = armed && hit && !arm && !cancel;
  assign wr_en   = fire || (filling && !arm && !cancel);
  assign wr_addr = fire ? '0 : cnt_q;
  assign last    = wr_en && (wr_addr == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (cancel) begin
      st_q <= ST_IDLE;
    end else if (arm) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (wr_en) begin
      cnt_q <= wr_addr + 1'b1;
      if (last) begin
        st_q <= ST_IDLE;
        done <= 1'b1;
      end else begin
        st_q <= ST_FILL;
      end
    end
  end

endmodule

// File: rtl/wcap_ram.sv
module wcap_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import wcap_pkg::*;
#(
  parameter int          NBITS   = 8,
  parameter int          DEPTH   = 32,
  parameter logic [31:0] VERSION = 32'h0000_0102
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] probe_in,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [31:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             user_sel
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             rsv_hit;
  logic [3:0]       off;
  logic             wr_hit;
  logic             arm_req;
  logic             cancel_req;
  logic [NBITS-1:0] m_rise, m_fall, m_high, m_low;
  logic [AW-1:0]    sample_idx;
  logic             trig_hit;
  logic             armed_w, filling_w, done_w, fire_w, wr_en_w;
  logic [AW-1:0]    wr_addr_w;
  logic [NBITS-1:0] ram_q;
  logic [31:0]      reg_view;
  logic [31:0]      reg_q;
  logic             from_ram_q;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign rsv_hit    = (bus_addr[31:4] == RSV_TAG);
  assign off        = bus_addr[3:0];
  assign user_sel   = (bus_rd || bus_wr) && !rsv_hit;
  assign wr_hit     = bus_wr && rsv_hit;
  assign arm_req    = wr_hit && (off == OFF_CTRL) && bus_wdata[0];
  assign cancel_req = wr_hit && (off == OFF_CTRL) && bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rise     <= '0;
      m_fall     <= '0;
      m_high     <= '0;
      m_low      <= '0;
      sample_idx <= '0;
    end else if (wr_hit) begin
      case (off)
        OFF_RISE:  m_rise     <= bus_wdata[NBITS-1:0];
        OFF_FALL:  m_fall     <= bus_wdata[NBITS-1:0];
        OFF_HIGH:  m_high     <= bus_wdata[NBITS-1:0];
        OFF_LOW:   m_low      <= bus_wdata[NBITS-1:0];
        OFF_INDEX: sample_idx <= bus_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  wcap_trig #(.W(NBITS)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .probe   (probe_in),
    .en_rise (m_rise),
    .en_fall (m_fall),
    .en_high (m_high),
    .en_low  (m_low),
    .hit     (trig_hit)
  );

  wcap_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm_req),
    .cancel  (cancel_req),
    .hit     (trig_hit),
    .armed   (armed_w),
    .filling (filling_w),
    .done    (done_w),
    .fire    (fire_w),
    .wr_en   (wr_en_w),
    .wr_addr (wr_addr_w)
  );

  wcap_ram #(.W(NBITS), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en_w),
    .waddr (wr_addr_w),
    .wdata (probe_in),
    .re    (bus_rd && rsv_hit && (off == OFF_DATA)),
    .raddr (sample_idx),
    .rdata (ram_q)
  );

  always_comb begin
    case (off)
      OFF_STAT:  reg_view = {29'b0, done_w, filling_w, armed_w};
      OFF_WIDTH: reg_view = 32'(NBITS);
      OFF_DEPTH: reg_view = 32'(DEPTH);
      OFF_VER:   reg_view = VERSION;
      OFF_RISE:  reg_view = 32'(m_rise);
      OFF_FALL:  reg_view = 32'(m_fall);
      OFF_HIGH:  reg_view = 32'(m_high);
      OFF_LOW:   reg_view = 32'(m_low);
      OFF_INDEX: reg_view = 32'(sample_idx);
      default:   reg_view = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q      <= '0;
      from_ram_q <= 1'b0;
    end else if (bus_rd && rsv_hit) begin
      reg_q      <= reg_view;
      from_ram_q <= (off == OFF_DATA);
    end
  end

  assign bus_rdata = from_ram_q ? 32'(ram_q) : reg_q;

endmodule

// File: rtl/wcap_chk.sv
module wcap_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          armed,
  input logic          filling,
  input logic          done,
  input logic          arm_req,
  input logic          cancel_req,
  input logic          hit,
  input logic          fire,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [31:0]   bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          user_sel
);

  // R9
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, filling, done}));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !arm_req |=> done);

  // R10
  cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_req |=> !armed && !filling);

  // R3
  arm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_req && !cancel_req |=> armed && !done);

  // R4
  fire_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> wr_en && (wr_addr == '0));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !hit && !arm_req && !cancel_req |=> armed);

  // R9
  fill_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filling && !arm_req && !cancel_req |-> wr_en);

  // R12
  rsv_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && (&bus_addr[31:4]) |-> !user_sel);

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind trig_capture wcap_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .armed      (armed_w),
  .filling    (filling_w),
  .done       (done_w),
  .arm_req    (arm_req),
  .cancel_req (cancel_req),
  .hit        (trig_hit),
  .fire       (fire_w),
  .wr_en      (wr_en_w),
  .wr_addr    (wr_addr_w),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .user_sel   (user_sel)
);

// File: tb/tb_trig_capture.sv
module tb_trig_capture;
  localparam int          NB   = 8;
  localparam int          DP   = 32;
  localparam int          IW   = $clog2(DP);
  localparam logic [31:0] VER  = 32'h0000_0102;
  localparam logic [31:0] BASE = 32'hFFFF_FFF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] din = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0]   bus_addr = '0, bus_wdata = '0;
  wire  [31:0]   bus_rdata;
  wire           user_sel;

  always #5 clk = ~clk;

  trig_capture dut (
    .clk(clk), .rst_n(rst_n), .probe_in(din), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .user_sel(user_sel)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    run = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int            m_st = 0;      // 0 idle, 1 waiting, 2 capturing
  bit            m_done = 1'b0;
  logic [NB-1:0] m_prev = '0, mr = '0, mf = '0, mh = '0, ml = '0;
  int            m_idx = 0;
  logic [31:0]   m_rdata = '0;
  bit            m_known = 1'b1;
  logic [NB-1:0] m_q[$];

  function automatic bit m_hit(input logic [NB-1:0] d);
    for (int i = 0; i < NB; i++) begin
      bit any, ok;
      any = mr[i] | mf[i] | mh[i] | ml[i];
      ok  = (mr[i] && d[i] && !m_prev[i]) || (mf[i] && !d[i] && m_prev[i])
         || (mh[i] && d[i]) || (ml[i] && !d[i]);
      if (any && !ok) return 1'b0;
    end
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    bit       rsv, arm, can, h;
    bit [3:0] off;
    rsv = (bus_addr[31:4] == 28'hFFF_FFFF);
    off = bus_addr[3:0];
    if (!rst_n) begin
      m_st = 0; m_done = 0; mr = '0; mf = '0; mh = '0; ml = '0;
      m_idx = 0; m_rdata = '0; m_known = 1;
    end else begin
      h   = m_hit(din);
      arm = bus_wr && rsv && off == 0 && bus_wdata[0];
      can = bus_wr && rsv && off == 0 && bus_wdata[1];
      if (bus_rd && rsv) begin
        m_known = 1;
        case (off)
          1:  m_rdata = {29'b0, m_done, m_st == 2, m_st == 1};
          2:  m_rdata = NB;
          3:  m_rdata = DP;
          4:  m_rdata = VER;
          5:  m_rdata = 32'(mr);
          6:  m_rdata = 32'(mf);
          7:  m_rdata = 32'(mh);
          8:  m_rdata = 32'(ml);
          9:  m_rdata = m_idx;
          10: if (m_idx < m_q.size()) m_rdata = 32'(m_q[m_idx]); else m_known = 0;
          default: m_rdata = '0;
        endcase
      end
      if (can) m_st = 0;
      else if (arm) begin m_st = 1; m_done = 0; m_q.delete(); end
      else if ((m_st == 1 && h) || m_st == 2) begin
        m_q.push_back(din);
        m_st = 2;
        if (m_q.size() == DP) begin m_st = 0; m_done = 1; end
      end
      if (bus_wr && rsv) begin
        case (off)
          5: mr = bus_wdata[NB-1:0];
          6: mf = bus_wdata[NB-1:0];
          7: mh = bus_wdata[NB-1:0];
          8: ml = bus_wdata[NB-1:0];
          9: m_idx = int'(bus_wdata[IW-1:0]);
          default: ;
        endcase
      end
      m_prev = din;
    end
    #2;
    if (m_known) check({cur_req, " rdata per-cycle"}, bus_rdata, m_rdata);
    check("R12 user_sel per-cycle", {31'b0, user_sel}, {31'b0, (bus_rd || bus_wr) && !rsv});
  end

  // free-running probe pattern
  always @(negedge clk) if (run) din = din + 1'b1;

  // ---------------- bus tasks ----------------
  task automatic wr_abs(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] o, input logic [31:0] d);
    wr_abs(BASE | 32'(o), d);
  endtask

  task automatic rd(input logic [3:0] o, output logic [31:0] v);
    @(negedge clk);
    bus_addr = BASE | 32'(o); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic set_masks(input logic [NB-1:0] r, input logic [NB-1:0] f,
                           input logic [NB-1:0] hi, input logic [NB-1:0] lo);
    wr(4'd5, 32'(r)); wr(4'd6, 32'(f)); wr(4'd7, 32'(hi)); wr(4'd8, 32'(lo));
  endtask

  task automatic drive(input logic [NB-1:0] v);
    @(negedge clk);
    din = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < 100; k++) begin
      rd(4'd1, v);
      if (v[2]) break;
    end
    check(req, v, 32'h4);
  endtask

  task automatic rd_sample(input int i, output logic [31:0] v);
    wr(4'd9, 32'(i));
    rd(4'd10, v);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [31:0] v, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd(4'd1, v); check("R1 status after reset", v, 32'h0);
    rd(4'd5, v); check("R1 rise mask after reset", v, 32'h0);
    rd(4'd8, v); check("R1 low mask after reset", v, 32'h0);
    rd(4'd9, v); check("R1 index after reset", v, 32'h0);

    cur_req = "R2";
    rd(4'd2, v); check("R2 width", v, NB);
    rd(4'd3, v); check("R2 depth", v, DP);
    rd(4'd4, v); check("R2 version", v, VER);

    cur_req = "R13";
    idle(3);
    check("R13 rdata holds between reads", bus_rdata, VER);

    cur_req = "R11";
    wr(4'd9, 32'd7); rd(4'd9, v); check("R11 index readback", v, 32'd7);

    // empty trigger set: starts at once, consecutive samples
    cur_req = "R4";
    run = 1'b1;
    wr(4'd0, 32'h1);
    rd(4'd1, v); check("R4 capturing right after arm", v, 32'h2);
    wait_done("R9 done after fill");
    run = 1'b0;
    rd_sample(0, s0);
    rd_sample(DP - 1, v);
    check("R9 last sample is consecutive", v, 32'((s0[NB-1:0] + NB'(DP - 1))));
    rd_sample(1, v);
    check("R9 second sample is consecutive", v, 32'((s0[NB-1:0] + NB'(1))));
    idle(10);
    rd(4'd1, v); check("R9 done sticky", v, 32'h4);

    // rising edge, no false edge at arm
    cur_req = "R5";
    set_masks(8'h01, 8'h00, 8'h00, 8'h00);
    drive(8'h01);
    wr(4'd0, 32'h1);
    idle(4);
    rd(4'd1, v); check("R3 waiting and done cleared; R5 no edge at arm", v, 32'h1);
    drive(8'h00); drive(8'h01);
    wait_done("R5 rising fired");
    rd_sample(0, v); check("R5 rising sample0", v, 32'h01);

    set_masks(8'h00, 8'h20, 8'h00, 8'h00);
    drive(8'h20);
    wr(4'd0, 32'h1);
    idle(3);
    rd(4'd1, v); check("R5 falling waits", v, 32'h1);
    drive(8'h00);
    wait_done("R5 falling fired");
    rd_sample(0, v); check("R5 falling sample0", v, 32'h00);

    // level conditions
    cur_req = "R6";
    set_masks(8'h00, 8'h00, 8'h08, 8'h00);
    drive(8'h00);
    wr(4'd0, 32'h1);
    idle(3);
    rd(4'd1, v); check("R6 high waits", v, 32'h1);
    drive(8'h08);
    wait_done("R6 high fired");
    rd_sample(0, v); check("R6 high sample0", v, 32'h08);

    set_masks(8'h00, 8'h00, 8'h00, 8'h02);
    drive(8'h02);
    wr(4'd0, 32'h1);
    idle(3);
    rd(4'd1, v); check("R6 low waits", v, 32'h1);
    drive(8'h40);
    wait_done("R6 low fired");
    rd_sample(0, v); check("R6 low sample0", v, 32'h40);

    // OR within one bit
    cur_req = "R7";
    set_masks(8'h10, 8'h10, 8'h00, 8'h00);
    drive(8'h90);
    wr(4'd0, 32'h1);
    idle(3);
    rd(4'd1, v); check("R7 no edge yet", v, 32'h1);
    drive(8'h80);
    wait_done("R7 falling alternative fired");
    rd_sample(0, v); check("R7 sample0", v, 32'h80);

    // AND across bits
    cur_req = "R8";
    set_masks(8'h01, 8'h00, 8'h02, 8'h00);
    drive(8'h00);
    wr(4'd0, 32'h1);
    drive(8'h01);
    idle(3);
    rd(4'd1, v); check("R8 edge alone does not fire", v, 32'h1);
    drive(8'h02); drive(8'h03);
    wait_done("R8 both bits fired");
    rd_sample(0, v); check("R8 sample0", v, 32'h03);

    // cancel
    cur_req = "R10";
    wr(4'd0, 32'h2);
    rd(4'd1, v); check("R10 cancel keeps done", v, 32'h4);
    set_masks(8'h00, 8'h00, 8'h01, 8'h00);
    drive(8'h00);
    wr(4'd0, 32'h1);
    rd(4'd1, v); check("R3 rearm clears done", v, 32'h1);
    wr(4'd0, 32'h2);
    rd(4'd1, v); check("R10 cancel returns idle", v, 32'h0);
    wr(4'd0, 32'h3);
    rd(4'd1, v); check("R10 cancel beats arm", v, 32'h0);

    // reserved window decode
    cur_req = "R12";
    @(negedge clk);
    bus_addr = 32'h0000_0005; bus_wdata = 32'hFF; bus_wr = 1'b1;
    #1 check("R12 user_sel on outside write", {31'b0, user_sel}, 32'h1);
    @(negedge clk); bus_wr = 1'b0;
    wr_abs(32'hFFFF_FFE5, 32'hFF);
    wr_abs(32'h0000_0000, 32'h1);
    rd(4'd5, v); check("R12 outside write left rise mask", v, 32'h0);
    rd(4'd1, v); check("R12 outside write did not arm", v, 32'h0);

    idle(2);
    report();
  end

endmodule